// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit virtual address into a 16-bit physical address through a four-entry segment table. The table lives in flip-flops. The two most significant address bits pick a segment and the remaining twelve bits form the offset inside it.

Each table entry holds the following fields:
- a valid flag;
- a read-only flag;
- a 16-bit physical base;
- a 13-bit segment size.

For each request the block checks the entry, compares the offset with the size and checks the access direction against the read-only flag. It then returns either base plus offset or a fault code. The result is registered, so it appears one clock after the request.

System control logic loads the table through a single-entry write port, one entry per cycle. The data path presents one request per cycle with a valid strobe and a write flag. A faulting access returns a zero address and a code that names the reason, which lets the surrounding logic raise the right exception.

Top module: `seg_xlate`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid` is 0. After reset every table entry is invalid, so any request made before a table write gets code 1.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In every other cycle it is low.
- R3: A request to a valid segment gives code 0 (no fault), `rsp_fault` low and `rsp_addr` = (base + offset) modulo 2^16. The offset is `req_addr[11:0]` and the segment is `req_addr[13:12]`.
- R4: An offset greater than or equal to the segment size gives code 2 (bound fault) with `rsp_addr` = 0.
- R5: A request to a segment whose valid flag is clear gives code 1 (missing segment) with `rsp_addr` = 0. This takes priority over every other fault.
- R6: A write (`req_write`=1) to a read-only segment gives code 3 (protection fault) with `rsp_addr` = 0. A read of a read-only segment translates normally.
- R7: When an access breaks both the bound and the read-only rule, the code is 2.
- R8: A table write takes effect for requests in later cycles. A request in the same cycle as the write to its segment sees the old entry.
- R9: `rsp_fault` is high exactly when the code is nonzero. While `rsp_valid` is low, `rsp_fault`, `rsp_code` and `rsp_addr` are all 0.
- R10: A valid segment with size 0 faults every access with code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Entry to write |
| tbl_valid | input | 1 | Valid flag written to the entry |
| tbl_ro | input | 1 | Read-only flag written to the entry |
| tbl_base | input | 16 | Physical base written to the entry |
| tbl_size | input | 13 | Segment size written to the entry (0 to 4096) |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 14 | Virtual address: segment in [13:12], offset in [11:0] |
| req_write | input | 1 | 1 for a store, 0 for a load or fetch |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 16 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Any fault |
| rsp_code | output | 2 | 0 none, 1 missing segment, 2 bound, 3 protection |

## Verification
The assertions assume that `req_addr`, `req_write` and the table write fields are known whenever their strobes are high, and that each write carries a size no larger than 4096. The bench drives every input at the falling edge, keeps all fields at defined values even while idle, and loads only sizes in that range. Corner cases covered:
- first and last legal offset of each segment;
- an offset exactly equal to the size;
- a zero size;
- base wrap-around;
- a write and a request to the same entry in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int SEG_W  = 2;
    localparam int OFF_W  = 12;
    localparam int PA_W   = 16;
    localparam int VA_W   = SEG_W + OFF_W;
    localparam int NSEG   = 1 << SEG_W;
    localparam int SIZE_W = OFF_W + 1;

    typedef struct packed {
        logic              valid;
        logic              ro;
        logic [PA_W-1:0]   base;
        logic [SIZE_W-1:0] size;
    } seg_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_MISS  = 2'd1,
        FLT_BOUND = 2'd2,
        FLT_PROT  = 2'd3
    } fault_e;

    function automatic logic in_bounds(logic [OFF_W-1:0] off, logic [SIZE_W-1:0] size);
        return {1'b0, off} < size;
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);
    seg_entry_t       ent [NSEG];
    logic [NSEG-1:0]  valid_vec;

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (we && wr_idx == SEG_W'(g)) begin
                ent[g] <= wr_entry;
            end
        end
        assign valid_vec[g] = ent[g].valid;
    end

    assign rd_entry = ent[rd_idx];

    // R1: reset leaves the whole table invalid
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> valid_vec == '0);
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  seg_entry_t       entry,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output logic [PA_W-1:0]  phys,
    output fault_e           code
);
    always_comb begin
        if (!entry.valid) begin
            code = FLT_MISS;
        end else if (!in_bounds(offset, entry.size)) begin
            code = FLT_BOUND;
        end else if (is_write && entry.ro) begin
            code = FLT_PROT;
        end else begin
            code = FLT_NONE;
        end
        phys = (code == FLT_NONE) ? entry.base + PA_W'(offset) : '0;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic              tbl_ro,
    input  logic [PA_W-1:0]   tbl_base,
    input  logic [SIZE_W-1:0] tbl_size,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_code
);
    seg_entry_t       wr_entry;
    seg_entry_t       cur;
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  phys;
    fault_e           code;

    assign seg      = req_addr[VA_W-1:OFF_W];
    assign off      = req_addr[OFF_W-1:0];
    assign wr_entry = '{valid: tbl_valid, ro: tbl_ro, base: tbl_base, size: tbl_size};

    seg_table u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .wr_idx(tbl_idx),
        .wr_entry(wr_entry), .rd_idx(seg), .rd_entry(cur)
    );

    seg_check u_check (
        .entry(cur), .offset(off), .is_write(req_write),
        .phys(phys), .code(code)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
            rsp_code  <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b1;
            rsp_addr  <= phys;
            rsp_fault <= (code != FLT_NONE);
            rsp_code  <= code;
        end
    end

    // R2: one-cycle latency strobe
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R3: clean access returns base plus offset
    p_xlate_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur.valid && in_bounds(off, cur.size) && !(req_write && cur.ro))
        |=> (rsp_code == 2'd0 && rsp_addr == $past(cur.base) + PA_W'($past(off))));
    // R4 / R7: bound fault beats protection
    p_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur.valid && !in_bounds(off, cur.size))
        |=> (rsp_code == 2'd2 && rsp_addr == '0));
    // R5: missing segment
    p_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur.valid) |=> (rsp_code == 2'd1 && rsp_addr == '0));
    // R6: store into read-only segment
    p_prot_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cur.valid && cur.ro && in_bounds(off, cur.size))
        |=> rsp_code == 2'd3);
    // R9: idle outputs are quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_fault && rsp_code == 2'd0 && rsp_addr == '0));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic        tbl_valid = 1'b0;
    logic        tbl_ro = 1'b0;
    logic [15:0] tbl_base = '0;
    logic [12:0] tbl_size = '0;
    logic        req_valid = 1'b0;
    logic [13:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_addr;
    logic        rsp_fault;
    logic [1:0]  rsp_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_valid(tbl_valid), .tbl_ro(tbl_ro), .tbl_base(tbl_base),
        .tbl_size(tbl_size), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] idx, input logic v, input logic ro,
                        input logic [15:0] base, input logic [12:0] size);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_valid = v; tbl_ro = ro;
        tbl_base = base; tbl_size = size;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // drive at a falling edge, result is registered at the next rising edge,
    // sampled at the following falling edge
    task automatic xlate(input string tag, input logic [1:0] seg, input logic [11:0] off,
                         input logic wr, input logic [1:0] exp_code, input logic [15:0] exp_addr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {seg, off}; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rsp_code === exp_code, tag, "rsp_code", 32'(rsp_code), 32'(exp_code));
        check(rsp_fault === (exp_code != 2'd0), tag, "rsp_fault", 32'(rsp_fault),
              32'(exp_code != 2'd0));
        check(rsp_addr === exp_addr, tag, "rsp_addr", 32'(rsp_addr), 32'(exp_addr));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) xlate("R1", 2'(s), 12'h000, 1'b0, 2'd1, 16'h0000);
    endtask

    task automatic t_example;
        load(2'd0, 1'b1, 1'b1, 16'h4000, 13'h0700);
        load(2'd1, 1'b1, 1'b0, 16'h0000, 13'h0500);
        load(2'd3, 1'b1, 1'b0, 16'h2000, 13'h1000);
        xlate("R3", 2'd0, 12'h000, 1'b0, 2'd0, 16'h4000);
        xlate("R3", 2'd0, 12'h6ff, 1'b0, 2'd0, 16'h46ff);
        xlate("R3", 2'd1, 12'h4ff, 1'b1, 2'd0, 16'h04ff);
        xlate("R3", 2'd3, 12'hfff, 1'b1, 2'd0, 16'h2fff);
        xlate("R4", 2'd0, 12'h700, 1'b0, 2'd2, 16'h0000);
        xlate("R4", 2'd1, 12'h500, 1'b0, 2'd2, 16'h0000);
        xlate("R5", 2'd2, 12'h000, 1'b0, 2'd1, 16'h0000);
    endtask

    task automatic t_protect;
        xlate("R6", 2'd0, 12'h010, 1'b1, 2'd3, 16'h0000);
        xlate("R6", 2'd0, 12'h010, 1'b0, 2'd0, 16'h4010);
        xlate("R7", 2'd0, 12'h800, 1'b1, 2'd2, 16'h0000);
    endtask

    task automatic t_edges;
        load(2'd1, 1'b1, 1'b0, 16'h0000, 13'h0000);
        xlate("R10", 2'd1, 12'h000, 1'b0, 2'd2, 16'h0000);
        load(2'd1, 1'b1, 1'b0, 16'hff00, 13'h0400);
        xlate("R3", 2'd1, 12'h200, 1'b0, 2'd0, 16'h0100);
        load(2'd1, 1'b0, 1'b1, 16'h1234, 13'h0400);
        xlate("R5", 2'd1, 12'h900, 1'b1, 2'd1, 16'h0000);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 2'd2; tbl_valid = 1'b1; tbl_ro = 1'b0;
        tbl_base = 16'h8000; tbl_size = 13'h0100;
        req_valid = 1'b1; req_addr = {2'd2, 12'h004}; req_write = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        check(rsp_code === 2'd1, "R8", "old entry seen", 32'(rsp_code), 32'd1);
        xlate("R8", 2'd2, 12'h004, 1'b0, 2'd0, 16'h8004);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2", "no strobe without request", 32'(rsp_valid), 32'd0);
        check(rsp_code === 2'd0 && rsp_fault === 1'b0 && rsp_addr === 16'h0, "R9",
              "idle outputs", {13'd0, rsp_fault, rsp_code, rsp_addr}, 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_protect();
        t_edges();
        t_same_cycle();
        t_idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule